// File: doc/BRIEF.md
# Capture/Reload Sixteen-Bit Timer

This block is a 16-bit up-counter paired with one 16-bit holding register. Depending on a mode select, the holding register serves either as a capture register or as a reload register. The counter advances on one of two sources. The first is an internal tick that fires once every twelve system clocks. The second is a falling edge on an external event pin, sampled through a synchronizer. A second external pin, the trigger, acts only on its falling edges.

In capture mode, a trigger edge copies the live count into the holding register. In reload mode, the counter is preloaded from the holding register when it wraps past its maximum. It can also be preloaded by a trigger edge. Either of two baud-clock override inputs forces reload-on-wrap behaviour and suppresses trigger actions. Two sticky flags record a wrap and a trigger edge. Each flag is cleared by a one-cycle clear pulse. Software loads the holding register through a write port.

Top module: `capReloadTimer`

## Requirements
- R1: After reset the count, the holding register, the wrap flag and the trigger flag all read 0.
- R2: With countSel=0 and runEn=1, the count increases by one every 12 clocks. Because the prescaler restarts whenever runEn is 0, the first increment lands on the 12th clock after runEn rises.
- R3: With countSel=1 and runEn=1, the count increases by one for each falling edge on evtPin. The internal tick has no effect in this mode.
- R4: While runEn=0 the count holds its value, except when a trigger-edge reload occurs.
- R5: With capSel=1 and both overrides 0, an increment from 0xFFFF gives 0x0000 and sets ovfFlag.
- R6: With capSel=0, an increment from 0xFFFF loads the count from the holding register and sets ovfFlag.
- R7: With capSel=1, extEn=1 and both overrides 0, a falling edge on trigPin copies the count into the holding register. This happens even while runEn=0. A rising edge on trigPin changes nothing.
- R8: With capSel=0, extEn=1 and both overrides 0, a falling edge on trigPin loads the count from the holding register.
- R9: With extEn=0, trigPin edges cause no capture, no reload and no flag.
- R10: If txClkOvr or rxClkOvr is 1, trigger edges neither capture nor reload, and a wrap reloads the count from the holding register, even when capSel=1.
- R11: A falling trigPin edge with extEn=1 sets extFlag, with or without override. The flags ovfFlag and extFlag stay set until a clear pulse on ovfClr or extClr. If a set and a clear happen in the same cycle, the set wins.
- R12: A pulse on crWrEn loads crWrData into the holding register. If a capture happens in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Enables counting |
| countSel | input | 1 | 0: internal tick, 1: evtPin falling edges |
| capSel | input | 1 | 1: capture mode, 0: reload mode |
| extEn | input | 1 | Enables trigger-pin actions |
| txClkOvr | input | 1 | Baud override, forces reload on wrap |
| rxClkOvr | input | 1 | Baud override, forces reload on wrap |
| trigPin | input | 1 | Asynchronous trigger pin, acts on falling edge |
| evtPin | input | 1 | Asynchronous event pin for external counting |
| crWrEn | input | 1 | Write strobe for the holding register |
| crWrData | input | 16 | Write data for the holding register |
| ovfClr | input | 1 | Clears ovfFlag |
| extClr | input | 1 | Clears extFlag |
| countVal | output | 16 | Live count |
| capVal | output | 16 | Holding register (capture or reload value) |
| ovfFlag | output | 1 | Sticky wrap flag |
| extFlag | output | 1 | Sticky trigger-edge flag |

## Verification
The bench places the count near 0xFFFF with a trigger-edge reload and then drives it across the wrap in each mode. This checks whether a design zeroes, reloads or forgets the flag when it wraps. A design that honoured capSel under an override would capture on the trigger edge or zero on the wrap, and the bench observes both through capVal and countVal. Capture is tried while the counter is stopped and on a rising trigger edge. A design that gated capture with runEn, or that acted on levels, would leave a wrong value in capVal. Counting with the event source checks that a design which still counted prescaler ticks drifts away from the edge count.

// File: rtl/timerPkg.sv
package timerPkg;
  // Control-to-datapath strobes, all valid for one clock
  typedef struct packed {
    logic countInc;    // advance the counter this cycle
    logic captureNow;  // copy count into holding register
    logic extReload;   // preload count from holding register (trigger)
    logic ovfReload;   // on wrap: 1 reload, 0 zero
    logic extSeen;     // qualified trigger edge occurred
  } tmrStrobes_t;
endpackage

// File: rtl/pinSync.sv
module pinSync (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic fallEdge
);
  logic stage1, stage2, prevSample;

  // Idle-high reset so no edge is seen leaving reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1     <= 1'b1;
      stage2     <= 1'b1;
      prevSample <= 1'b1;
    end else begin
      stage1     <= pinIn;
      stage2     <= stage1;
      prevSample <= stage2;
    end
  end

  assign fallEdge = prevSample & ~stage2;
endmodule

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import timerPkg::*;
#(
  parameter int PRESCALE = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        countSel,
  input  logic        capSel,
  input  logic        extEn,
  input  logic        txClkOvr,
  input  logic        rxClkOvr,
  input  logic        trigPin,
  input  logic        evtPin,
  output tmrStrobes_t strb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tickNow;
  logic             trigFall, evtFall;
  logic             baudOvr;

  pinSync u_trigSync (.clk(clk), .rstN(rstN), .pinIn(trigPin), .fallEdge(trigFall));
  pinSync u_evtSync  (.clk(clk), .rstN(rstN), .pinIn(evtPin),  .fallEdge(evtFall));

  // Prescaler restarts while stopped so the first tick is a full period away
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 preCnt <= '0;
    else if (!runEn)           preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else                       preCnt <= preCnt + 1'b1;
  end

  assign tickNow = runEn && (preCnt == PRE_LAST);
  assign baudOvr = txClkOvr | rxClkOvr;

  always_comb begin
    strb            = '0;
    strb.countInc   = runEn & (countSel ? evtFall : tickNow);
    strb.extSeen    = extEn & trigFall;
    strb.captureNow = strb.extSeen & capSel & ~baudOvr;
    strb.extReload  = strb.extSeen & ~capSel & ~baudOvr;
    strb.ovfReload  = baudOvr | ~capSel;
  end
endmodule

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import timerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strb,
  input  logic             crWrEn,
  input  logic [CNT_W-1:0] crWrData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] crVal,
  output logic             ovfFlag,
  output logic             extFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrapNow;
  assign wrapNow = strb.countInc && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strb.extReload)  cnt <= crVal;
    else if (wrapNow)         cnt <= strb.ovfReload ? crVal : '0;
    else if (strb.countInc)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                crVal <= '0;
    else if (strb.captureNow) crVal <= cnt;
    else if (crWrEn)          crVal <= crWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      ovfFlag <= wrapNow | (ovfFlag & ~ovfClr);
      extFlag <= strb.extSeen | (extFlag & ~extClr);
    end
  end
endmodule

// File: rtl/capReloadTimer.sv
module capReloadTimer
  import timerPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             countSel,
  input  logic             capSel,
  input  logic             extEn,
  input  logic             txClkOvr,
  input  logic             rxClkOvr,
  input  logic             trigPin,
  input  logic             evtPin,
  input  logic             crWrEn,
  input  logic [CNT_W-1:0] crWrData,
  input  logic             ovfClr,
  input  logic             extClr,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] capVal,
  output logic             ovfFlag,
  output logic             extFlag
);
  tmrStrobes_t strb;

  tmrCtrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .countSel(countSel),
    .capSel(capSel), .extEn(extEn), .txClkOvr(txClkOvr),
    .rxClkOvr(rxClkOvr), .trigPin(trigPin), .evtPin(evtPin), .strb(strb)
  );

  tmrDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .crWrEn(crWrEn),
    .crWrData(crWrData), .ovfClr(ovfClr), .extClr(extClr),
    .cnt(countVal), .crVal(capVal), .ovfFlag(ovfFlag), .extFlag(extFlag)
  );
endmodule

// File: rtl/tmrChecker.sv
module tmrChecker
  import timerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             txClkOvr,
  input logic             rxClkOvr,
  input tmrStrobes_t      strb,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] crVal,
  input logic             ovfFlag,
  input logic             extFlag
);
  // R4
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !strb.extReload) |=> cnt == $past(cnt));

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countInc && cnt == '1 && !strb.ovfReload && !strb.extReload) |=> cnt == '0);

  // R6
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countInc && cnt == '1) |=> ovfFlag);

  // R7
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureNow |=> crVal == $past(cnt));

  // R10
  override_blocks_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txClkOvr || rxClkOvr) |-> (!strb.captureNow && !strb.extReload));

  // R11
  ext_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.extSeen |=> extFlag);

  // R8
  trig_action_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.captureNow, strb.extReload}));
endmodule

bind capReloadTimer tmrChecker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .txClkOvr(txClkOvr),
  .rxClkOvr(rxClkOvr), .strb(strb), .cnt(countVal), .crVal(capVal),
  .ovfFlag(ovfFlag), .extFlag(extFlag)
);

// File: tb/capReloadTimer_bench.sv
module capReloadTimer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, countSel = 0, capSel = 0, extEn = 0;
  logic txClkOvr = 0, rxClkOvr = 0, trigPin = 1, evtPin = 1;
  logic crWrEn = 0, ovfClr = 0, extClr = 0;
  logic [15:0] crWrData = '0;
  logic [15:0] countVal, capVal;
  logic ovfFlag, extFlag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capReloadTimer u_capReloadTimer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .countSel(countSel),
    .capSel(capSel), .extEn(extEn), .txClkOvr(txClkOvr), .rxClkOvr(rxClkOvr),
    .trigPin(trigPin), .evtPin(evtPin), .crWrEn(crWrEn), .crWrData(crWrData),
    .ovfClr(ovfClr), .extClr(extClr), .countVal(countVal), .capVal(capVal),
    .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic trigFallRise();
    @(negedge clk) trigPin = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) trigPin = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trigFallOnly();
    @(negedge clk) trigPin = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trigRiseOnly();
    @(negedge clk) trigPin = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic evtPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) evtPin = 0;
      repeat (4) @(posedge clk);
      @(negedge clk) evtPin = 1;
      repeat (4) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic writeCr(input logic [15:0] v);
    @(negedge clk) begin crWrEn = 1; crWrData = v; end
    @(negedge clk) crWrEn = 0;
  endtask

  task automatic clearFlags();
    @(negedge clk) begin ovfClr = 1; extClr = 1; end
    @(negedge clk) begin ovfClr = 0; extClr = 0; end
  endtask

  task automatic testReset();
    chk("R1 count", countVal, 0);
    chk("R1 holding", capVal, 0);
    chk("R1 flags", {ovfFlag, extFlag}, 0);
  endtask

  task automatic testTickAndHold();
    @(negedge clk) begin countSel = 0; runEn = 1; end
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R2 tick count", countVal, 5);
    runEn = 0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R4 hold while stopped", countVal, 5);
  endtask

  task automatic testEvents();
    @(negedge clk) begin countSel = 1; runEn = 1; end
    evtPulses(3);
    chk("R3 event count", countVal, 8);
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R3 tick ignored in event mode", countVal, 8);
    runEn = 0;
  endtask

  task automatic testWriteAndEdgeReload();
    writeCr(16'h1234);
    chk("R12 write holding", capVal, 16'h1234);
    @(negedge clk) begin capSel = 0; extEn = 1; end
    trigFallRise();
    chk("R8 edge reload", countVal, 16'h1234);
    chk("R11 ext flag set", extFlag, 1);
    clearFlags();
    chk("R11 ext flag cleared", extFlag, 0);
  endtask

  task automatic testReloadWrap();
    writeCr(16'hFFFD);
    trigFallRise();
    chk("R8 preload near max", countVal, 16'hFFFD);
    writeCr(16'h0100);
    @(negedge clk) begin runEn = 1; countSel = 1; end
    evtPulses(2);
    chk("R6 before wrap", {15'd0, ovfFlag, countVal}, 32'h0000FFFF);
    evtPulses(1);
    chk("R6 reload on wrap", countVal, 16'h0100);
    chk("R6 wrap flag", ovfFlag, 1);
    runEn = 0;
    clearFlags();
    chk("R11 ovf flag cleared", ovfFlag, 0);
  endtask

  task automatic testCaptureWrap();
    writeCr(16'hFFFE);
    @(negedge clk) capSel = 0;
    trigFallRise();
    chk("R8 preload FFFE", countVal, 16'hFFFE);
    @(negedge clk) begin capSel = 1; runEn = 1; countSel = 1; end
    evtPulses(2);
    chk("R5 wrap to zero", countVal, 0);
    chk("R5 wrap flag", ovfFlag, 1);
    chk("R5 holding untouched", capVal, 16'hFFFE);
    evtPulses(2);
    runEn = 0;
    trigFallOnly();
    chk("R7 capture while stopped", capVal, 2);
    @(negedge clk) runEn = 1;
    evtPulses(1);
    runEn = 0;
    trigRiseOnly();
    chk("R7 rising edge no capture", capVal, 2);
    chk("R7 count moved on", countVal, 3);
  endtask

  task automatic testExtDisabled();
    clearFlags();
    @(negedge clk) extEn = 0;
    trigFallRise();
    chk("R9 no capture", capVal, 2);
    chk("R9 no flag", extFlag, 0);
    @(negedge clk) capSel = 0;
    trigFallRise();
    chk("R9 no reload", countVal, 3);
    chk("R9 no flag reload mode", extFlag, 0);
  endtask

  task automatic testOverride();
    @(negedge clk) begin extEn = 1; capSel = 1; txClkOvr = 1; end
    trigFallRise();
    chk("R10 no capture under override", capVal, 2);
    chk("R11 flag under override", extFlag, 1);
    @(negedge clk) capSel = 0;
    trigFallRise();
    chk("R10 no edge reload under override", countVal, 3);
    @(negedge clk) txClkOvr = 0;
    writeCr(16'hFFFE);
    trigFallRise();
    chk("R8 preload for override wrap", countVal, 16'hFFFE);
    clearFlags();
    @(negedge clk) begin rxClkOvr = 1; capSel = 1; end
    writeCr(16'h0042);
    @(negedge clk) begin runEn = 1; countSel = 1; end
    evtPulses(2);
    chk("R10 reload on wrap despite capSel", countVal, 16'h0042);
    chk("R10 wrap flag", ovfFlag, 1);
    runEn = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    testReset();
    testTickAndHold();
    testEvents();
    testWriteAndEdgeReload();
    testReloadWrap();
    testCaptureWrap();
    testExtDisabled();
    testOverride();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule